// File: doc/BRIEF.md
# Instruction Cycle Cost Engine

This block sits beside the execution stage of an 8-bit accumulator processor model and prices each retired instruction in clock cycles. The decoder hands it, for every instruction, a base count, the kind of memory access the instruction makes, its addressing mode and the addresses it touched. The engine adds the page-crossing and branch penalties and returns the final count one clock later. It also keeps a running total of all cycles since reset.

A read that goes through an indexed mode and lands in a different 256-byte page costs one more cycle. Stores and read-modify-write operations pay their fixed worst-case count whether or not a page is crossed. A taken branch costs one extra cycle, or two if its target lies in another page than the address following the branch. Hardware interrupt entry has a fixed price. Undefined opcodes and fixed-cost instructions such as calls, returns, jumps and stack operations pass their base count through unchanged.

Top module: `cycle_cost_engine`

## Requirements
- R1: While reset is asserted and until the first request, `done` is 0 and `instr_cycles` and `total_cycles` are 0.
- R2: `done` is high in exactly the cycles that follow a cycle with `in_valid` high, so back-to-back requests give back-to-back results.
- R3: With `access_class` = 1 (read) and `addr_mode` in 1, 2 or 3 (indexed by X, by Y, or indirect then indexed by Y), the result is base + 1 when `base_addr` and `eff_addr` differ in bits [15:8].
- R4: A read adds nothing when those upper bits match, and a read with `addr_mode` = 0 (unindexed) adds nothing even when the two addresses lie in different pages.
- R5: With `access_class` = 2 (write), 3 (read-modify-write) or 0 (no data access), no page-crossing cycle is added in any mode.
- R6: With `is_branch` = 1 and `branch_taken` = 0 the result equals the base count, whatever the access and address inputs are.
- R7: A taken branch whose `branch_target` has the same bits [15:8] as `pc_next` costs base + 1.
- R8: A taken branch whose `branch_target` differs from `pc_next` in bits [15:8] costs base + 2. The penalty is never more than 2.
- R9: With `irq_entry` = 1 the result is IRQ_CYCLES (default 7), whatever the base count and the other penalty inputs are.
- R10: Each request adds its result to `total_cycles`, which wraps modulo 2^TOTAL_W.
- R11: In cycles without a request, `instr_cycles` and `total_cycles` keep their values.
- R12: When no penalty applies, the result equals `base_cycles` for any base value from 1 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | One-cycle strobe: the remaining inputs describe one instruction |
| base_cycles | input | BASE_W | Base cycle count from the decoder |
| access_class | input | 2 | 0 none, 1 read, 2 write, 3 read-modify-write |
| addr_mode | input | 2 | 0 unindexed, 1 indexed X, 2 indexed Y, 3 indirect indexed Y |
| base_addr | input | ADDR_W | Address before indexing |
| eff_addr | input | ADDR_W | Effective address after indexing |
| is_branch | input | 1 | Instruction is a conditional or unconditional relative branch |
| branch_taken | input | 1 | The branch was taken |
| pc_next | input | ADDR_W | Program counter after the offset byte was fetched |
| branch_target | input | ADDR_W | Program counter after the offset was applied |
| irq_entry | input | 1 | The request is a hardware interrupt entry |
| done | output | 1 | Result strobe, one cycle after `in_valid` |
| instr_cycles | output | BASE_W+1 | Cycles charged to the last request |
| total_cycles | output | TOTAL_W | Running cycle total since reset |

## Verification
The bench builds the engine with TOTAL_W = 12 and keeps the other parameters at their defaults. With the narrow total, a stream of about five hundred eight-cycle requests carries the counter across its wrap point, so the modulo rule of R10 is checked in a short run. The 16-bit addresses with an 8-bit page offset keep the page-crossing cases true to the full-width behaviour.

// File: rtl/cyc_cost_pkg.sv
package cyc_cost_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_RMW   = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'd0,
    MODE_IDX_X = 2'd1,
    MODE_IDX_Y = 2'd2,
    MODE_IND_Y = 2'd3
  } mode_e;

  // Extra cycle for an indexed read that crossed a page.
  function automatic logic [1:0] index_penalty(input access_e acc, input mode_e mode,
                                               input logic crossed);
    logic indexed;
    indexed = (mode != MODE_PLAIN);
    if (acc == ACC_READ && indexed && crossed) return 2'd1;
    return 2'd0;
  endfunction

  // Extra cycles for a relative branch: one when taken, two when taken into another page.
  function automatic logic [1:0] branch_penalty(input logic taken, input logic crossed);
    if (!taken) return 2'd0;
    if (crossed) return 2'd2;
    return 2'd1;
  endfunction

endpackage

// File: rtl/cyc_page_cross.sv
module cyc_page_cross #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 8
) (
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  output logic              crossed
);
  localparam int PAGE_W = ADDR_W - OFFS_W;

  function automatic logic pages_differ(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] b);
    logic [ADDR_W-1:0] diff;
    diff = a ^ b;
    return |diff[OFFS_W +: PAGE_W];
  endfunction

  assign crossed = pages_differ(addr_a, addr_b);
endmodule

// File: rtl/cyc_penalty_sel.sv
module cyc_penalty_sel
  import cyc_cost_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    valid,
  input  access_e acc,
  input  mode_e   mode,
  input  logic    data_cross,
  input  logic    is_branch,
  input  logic    taken,
  input  logic    branch_cross,
  input  logic    irq,
  output logic [1:0] extra
);
  logic [1:0] idx_extra;
  logic [1:0] br_extra;

  assign idx_extra = index_penalty(acc, mode, data_cross);
  assign br_extra  = branch_penalty(taken, branch_cross);

  // Priority: interrupt entry, then branch, then indexed data access.
  always_comb begin
    if (irq)            extra = 2'd0;
    else if (is_branch) extra = br_extra;
    else                extra = idx_extra;
  end

  AST_READ_CROSS_ADDS: assert property (@(posedge clk) disable iff (!rst_n) (valid && !irq && !is_branch && acc == ACC_READ && mode != MODE_PLAIN && data_cross) |-> (extra == 2'd1)); // R3
  AST_NO_WRITE_PENALTY: assert property (@(posedge clk) disable iff (!rst_n) (valid && !irq && !is_branch && acc != ACC_READ) |-> (extra == 2'd0)); // R5
  AST_NOT_TAKEN_FLAT: assert property (@(posedge clk) disable iff (!rst_n) (valid && !irq && is_branch && !taken) |-> (extra == 2'd0)); // R6
  AST_EXTRA_BOUND: assert property (@(posedge clk) disable iff (!rst_n) valid |-> (extra != 2'd3)); // R8
endmodule

// File: rtl/cyc_total_accum.sv
module cyc_total_accum #(
  parameter int ADD_W   = 5,
  parameter int TOTAL_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               add_valid,
  input  logic [ADD_W-1:0]   add_val,
  output logic [TOTAL_W-1:0] total
);
  logic [TOTAL_W-1:0] add_ext;

  generate
    if (TOTAL_W > ADD_W) begin : g_widen
      assign add_ext = {{(TOTAL_W-ADD_W){1'b0}}, add_val};
    end else begin : g_trim
      assign add_ext = add_val[TOTAL_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         total <= '0;
    else if (add_valid) total <= total + add_ext;
  end

  AST_TOTAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !add_valid |=> $stable(total)); // R11
endmodule

// File: rtl/cycle_cost_engine.sv
module cycle_cost_engine
  import cyc_cost_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int OFFS_W     = 8,
  parameter int BASE_W     = 4,
  parameter int TOTAL_W    = 64,
  parameter int IRQ_CYCLES = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [BASE_W-1:0]  base_cycles,
  input  logic [1:0]         access_class,
  input  logic [1:0]         addr_mode,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic [ADDR_W-1:0]  eff_addr,
  input  logic               is_branch,
  input  logic               branch_taken,
  input  logic [ADDR_W-1:0]  pc_next,
  input  logic [ADDR_W-1:0]  branch_target,
  input  logic               irq_entry,
  output logic               done,
  output logic [BASE_W:0]    instr_cycles,
  output logic [TOTAL_W-1:0] total_cycles
);
  localparam int OUT_W = BASE_W + 1;
  localparam logic [OUT_W-1:0] IRQ_COST = IRQ_CYCLES[OUT_W-1:0];

  logic             data_cross;
  logic             branch_cross;
  logic [1:0]       extra;
  logic [OUT_W-1:0] cost_next;

  cyc_page_cross #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_data_page (
    .addr_a(base_addr), .addr_b(eff_addr), .crossed(data_cross)
  );

  cyc_page_cross #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_branch_page (
    .addr_a(pc_next), .addr_b(branch_target), .crossed(branch_cross)
  );

  cyc_penalty_sel u_penalty (
    .clk(clk), .rst_n(rst_n), .valid(in_valid),
    .acc(access_e'(access_class)), .mode(mode_e'(addr_mode)),
    .data_cross(data_cross), .is_branch(is_branch), .taken(branch_taken),
    .branch_cross(branch_cross), .irq(irq_entry), .extra(extra)
  );

  always_comb begin
    if (irq_entry) cost_next = IRQ_COST;
    else           cost_next = {1'b0, base_cycles} + {{(OUT_W-2){1'b0}}, extra};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done         <= 1'b0;
      instr_cycles <= '0;
    end else begin
      done <= in_valid;
      if (in_valid) instr_cycles <= cost_next;
    end
  end

  cyc_total_accum #(.ADD_W(OUT_W), .TOTAL_W(TOTAL_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .add_valid(in_valid), .add_val(cost_next), .total(total_cycles)
  );

  AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> done); // R2
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !done); // R2
  AST_IRQ_FIXED: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && irq_entry) |=> (instr_cycles == IRQ_COST)); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(instr_cycles)); // R11
endmodule

// File: tb/cycle_cost_engine_bench.sv
module cycle_cost_engine_bench;
  localparam int AW = 16;
  localparam int OW = 8;
  localparam int BW = 4;
  localparam int TW = 12;
  localparam int IRQC = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [BW-1:0] base_cycles = '0;
  logic [1:0]    access_class = '0;
  logic [1:0]    addr_mode = '0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] eff_addr = '0;
  logic          is_branch = 1'b0;
  logic          branch_taken = 1'b0;
  logic [AW-1:0] pc_next = '0;
  logic [AW-1:0] branch_target = '0;
  logic          irq_entry = 1'b0;
  logic          done;
  logic [BW:0]   instr_cycles;
  logic [TW-1:0] total_cycles;

  always #10 clk = ~clk;

  cycle_cost_engine #(.ADDR_W(AW), .OFFS_W(OW), .BASE_W(BW), .TOTAL_W(TW), .IRQ_CYCLES(IRQC)) u_cycle_cost_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .base_cycles(base_cycles),
    .access_class(access_class), .addr_mode(addr_mode), .base_addr(base_addr),
    .eff_addr(eff_addr), .is_branch(is_branch), .branch_taken(branch_taken),
    .pc_next(pc_next), .branch_target(branch_target), .irq_entry(irq_entry),
    .done(done), .instr_cycles(instr_cycles), .total_cycles(total_cycles)
  );

  typedef struct {
    int            cyc;
    logic [TW-1:0] tot;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  int            compared = 0;
  int            mismatched = 0;
  logic [TW-1:0] run_total = '0;
  int            grand_sum = 0;
  int            last_cyc = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit other_page(input int a, input int b);
    return ((a / 256) % 256) != ((b / 256) % 256);
  endfunction

  // Driver: computes the expected cost from the rules and queues it.
  task automatic send(input int base, input int acc, input int mode, input int ba, input int ea,
                      input bit br, input bit tk, input int pcn, input int tgt,
                      input bit irq, input string tag);
    int cyc;
    if (irq)                cyc = IRQC;
    else if (br && !tk)     cyc = base;
    else if (br)            cyc = base + (other_page(pcn, tgt) ? 2 : 1);
    else if (acc == 1 && mode != 0 && other_page(ba, ea)) cyc = base + 1;
    else                    cyc = base;
    @(negedge clk);
    in_valid      = 1'b1;
    base_cycles   = BW'(base);
    access_class  = 2'(acc);
    addr_mode     = 2'(mode);
    base_addr     = AW'(ba);
    eff_addr      = AW'(ea);
    is_branch     = br;
    branch_taken  = tk;
    pc_next       = AW'(pcn);
    branch_target = AW'(tgt);
    irq_entry     = irq;
    run_total     = run_total + TW'(cyc);
    grand_sum     = grand_sum + cyc;
    last_cyc      = cyc;
    sb.push_back('{cyc, run_total, tag});
  endtask

  // Drops the strobe, waits, then checks the outputs are quiet and held (R2, R11).
  task automatic idle_check(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
    check(done == 1'b0, "R2", "done after idle", longint'(done), 0);
    check(total_cycles == run_total, "R11", "total held", longint'(total_cycles), longint'(run_total));
    check(int'(instr_cycles) == last_cyc, "R11", "result held", longint'(instr_cycles), longint'(last_cyc));
  endtask

  // Monitor: pops one expected item for every result strobe.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2", "done without request", 1, 0);
      end else begin
        e = sb.pop_front();
        check(int'(instr_cycles) == e.cyc, e.tag, "instr_cycles", longint'(instr_cycles), longint'(e.cyc));
        check(total_cycles == e.tot, "R10", "total_cycles", longint'(total_cycles), longint'(e.tot));
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
    check(instr_cycles == '0, "R1", "instr in reset", longint'(instr_cycles), 0);
    check(total_cycles == '0, "R1", "total in reset", longint'(total_cycles), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(total_cycles == '0 && done == 1'b0, "R1", "quiet after reset", longint'(total_cycles), 0);

    // R3: indexed reads crossing a page
    send(4, 1, 1, 'h12F0, 'h1310, 0, 0, 0, 0, 0, "R3");
    idle_check(1);
    send(5, 1, 3, 'h20FF, 'h2100, 0, 0, 0, 0, 0, "R3");
    send(4, 1, 2, 'hFFF0, 'h0005, 0, 0, 0, 0, 0, "R3");
    idle_check(2);

    // R4: same page, and unindexed with distant addresses
    send(4, 1, 2, 'h1200, 'h12FF, 0, 0, 0, 0, 0, "R4");
    send(4, 1, 0, 'h1000, 'h2000, 0, 0, 0, 0, 0, "R4");
    idle_check(1);

    // R5: write, read-modify-write and no-access classes never pay the crossing
    send(5, 2, 1, 'h12F0, 'h1310, 0, 0, 0, 0, 0, "R5");
    send(6, 3, 2, 'h30FF, 'h3101, 0, 0, 0, 0, 0, "R5");
    send(2, 0, 3, 'h40FF, 'h4101, 0, 0, 0, 0, 0, "R5");
    idle_check(1);

    // R6: branch not taken, even with crossing data inputs and distant pcs
    send(2, 0, 0, 0, 0, 1, 0, 'h03F0, 'h0410, 0, "R6");
    send(2, 1, 1, 'h12F0, 'h1310, 1, 0, 'h0300, 'h0500, 0, "R6");
    idle_check(1);

    // R7 / R8: taken branches
    send(2, 0, 0, 0, 0, 1, 1, 'h0310, 'h0380, 0, "R7");
    send(2, 0, 0, 0, 0, 1, 1, 'h03F0, 'h0410, 0, "R8");
    send(2, 0, 0, 0, 0, 1, 1, 'h0405, 'h03F0, 0, "R8");
    idle_check(1);

    // R9: interrupt entry overrides every other input
    send(3, 1, 1, 'h12F0, 'h1310, 0, 0, 0, 0, 1, "R9");
    send(15, 0, 0, 0, 0, 1, 1, 'h03F0, 'h0410, 1, "R9");
    idle_check(1);

    // R12: plain base counts pass through
    send(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    send(6, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    send(3, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    send(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    send(8, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    send(15, 1, 1, 'h5000, 'h5010, 0, 0, 0, 0, 0, "R12");
    idle_check(1);

    // R10: accumulate past the narrow total's wrap point
    for (int i = 0; i < 520; i++) begin
      send(8, 2, 1, 'h12F0, 'h1310, 0, 0, 0, 0, 0, "R10");
    end
    idle_check(2);
    check(grand_sum > (1 << TW), "R10", "sum passed wrap", longint'(grand_sum), longint'(1 << TW));
    check(int'(total_cycles) == (grand_sum % (1 << TW)), "R10", "total modulo",
          longint'(total_cycles), longint'(grand_sum % (1 << TW)));
    check(sb.size() == 0, "R2", "all results returned", longint'(sb.size()), 0);

    finish_run();
  end
endmodule